// File: doc/BRIEF.md
# Indirect Nibble Store Execute Unit

This unit decodes and executes a small family of 13-bit store instructions for a processor with a 4-bit data path and a 16-bit address space. There are two forms. The register form writes data register A or B to the address held in index register X or Y, then increments that index register. The immediate form writes a 4-bit constant, taken from the low opcode bits, through X or Y and leaves the index register unchanged.

The unit owns the X and Y index registers, an 8-bit extension register and an extension-pending flag. An extension prefix instruction fills the extension register and raises the flag. The next executed instruction always clears the flag. If that instruction is an immediate store, the address is built from the extension value in a fixed page: page 0x00 for X, page 0xFF for Y. The register form never uses the extension.

Every store completes in one cycle. On the clock edge where the instruction executes, the unit registers a single-cycle write strobe with its address and data, and updates the index registers on the same edge. Other parts of the core write X or Y through a load port.

Top module: `nibble_store_xu`

## Requirements
- R1: When `exec` is high and `pfx` is low, an opcode matching 0x1EE9 in every bit except bits 1 and 2 is a register store. Bit 1 = 1 selects Y (0 selects X) as the address. Bit 2 = 1 selects `reg_b` (0 selects `reg_a`) as the data. This covers 0x1EE9, 0x1EED, 0x1EEB and 0x1EEF.
- R2: A register store increments the selected index register by one, wrapping from 0xFFFF to 0x0000. The other index register keeps its value.
- R3: Opcodes 0x1E80–0x1E8F store through X and opcodes 0x1EA0–0x1EAF store through Y (bit 5 = 1 selects Y). The data is opcode bits 3..0. Neither index register changes.
- R4: If the extension flag is set when an immediate store executes, the address is 0x0000 + ext when bit 5 is 0, or 0xFF00 + ext when bit 5 is 1. The index register contents play no part.
- R5: A register store uses the index register as its address even when the extension flag is set.
- R6: `exec` with `pfx` high loads `ext_imm` into the extension register, sets the flag, and produces no write. The flag keeps its value on cycles where `exec` is low.
- R7: Any other executed instruction clears the flag, whether or not it is a store.
- R8: After the edge that executes a store, `mem_we` is high for exactly one cycle, with `mem_addr` and `mem_wdata` valid. `mem_we` is never high unless a store executed on the previous edge.
- R9: Unrecognised opcodes, and cycles with `exec` low, produce no write and leave X and Y unchanged.
- R10: `x_ld` or `y_ld` loads `ld_val` into X or Y and takes priority over a post-increment on the same edge. A store on that edge still uses the old index value as its address.
- R11: A synchronous `rst` clears X, Y, the extension register, the flag and the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | An instruction executes this cycle |
| pfx | input | 1 | The executing instruction is the extension prefix |
| insn | input | 13 | Instruction word |
| ext_imm | input | 8 | Prefix operand |
| reg_a | input | 4 | Data register A |
| reg_b | input | 4 | Data register B |
| x_ld | input | 1 | Load X from `ld_val` |
| y_ld | input | 1 | Load Y from `ld_val` |
| ld_val | input | 16 | Index load value |
| mem_we | output | 1 | Data-memory write strobe |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 4 | Write data |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| ext_pending | output | 1 | Extension flag |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, 4-bit data, 13-bit instructions and an 8-bit extension. With these values the 0xFFFF-to-0x0000 wrap is one load away, and both extended pages (0x00xx and 0xFFxx) are reached by a prefix followed by an immediate store. The 13-bit opcode space is small enough that random words land on near-miss encodings alongside the four register opcodes and thirty-two immediate opcodes.

// File: rtl/nibble_store_xu.sv
module nibble_store_xu #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter int INSN_W = 13,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  logic              pfx,
  input  logic [INSN_W-1:0] insn,
  input  logic [EXT_W-1:0]  ext_imm,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic              x_ld,
  input  logic              y_ld,
  input  logic [ADDR_W-1:0] ld_val,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] idx_x,
  output logic [ADDR_W-1:0] idx_y,
  output logic              ext_pending
);
  localparam int PAGE_W = ADDR_W - EXT_W;
  localparam logic [INSN_W-1:0] REG_BASE = INSN_W'('h1EE9);
  localparam logic [INSN_W-1:0] REG_MASK = INSN_W'('h1FF9);
  localparam logic [INSN_W-1:0] IMM_BASE = INSN_W'('h1E80);
  localparam logic [INSN_W-1:0] IMM_MASK = INSN_W'('h1FD0);

  logic [ADDR_W-1:0] x_q, y_q, base, st_addr;
  logic [EXT_W-1:0]  ext_q;
  logic              pend_q;
  logic              is_reg, is_imm, sel_y;
  logic [DATA_W-1:0] st_data;

  assign is_reg  = exec & ~pfx & ((insn & REG_MASK) == REG_BASE);
  assign is_imm  = exec & ~pfx & ((insn & IMM_MASK) == IMM_BASE);
  assign sel_y   = is_reg ? insn[1] : insn[5];
  assign base    = sel_y ? y_q : x_q;
  assign st_addr = (is_imm & pend_q) ? {{PAGE_W{sel_y}}, ext_q} : base;
  assign st_data = is_reg ? (insn[2] ? reg_b : reg_a) : insn[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q       <= '0;
      y_q       <= '0;
      ext_q     <= '0;
      pend_q    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= is_reg | is_imm;
      if (is_reg | is_imm) begin
        mem_addr  <= st_addr;
        mem_wdata <= st_data;
      end
      if (exec) begin
        if (pfx) begin
          ext_q  <= ext_imm;
          pend_q <= 1'b1;
        end else begin
          pend_q <= 1'b0;
        end
      end
      if (x_ld)                   x_q <= ld_val;
      else if (is_reg & ~insn[1]) x_q <= x_q + ADDR_W'(1);
      if (y_ld)                   y_q <= ld_val;
      else if (is_reg & insn[1])  y_q <= y_q + ADDR_W'(1);
    end
  end

  assign idx_x       = x_q;
  assign idx_y       = y_q;
  assign ext_pending = pend_q;
endmodule

// File: rtl/nibble_store_xu_chk.sv
module nibble_store_xu_chk #(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 13,
  parameter int EXT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              exec,
  input logic              pfx,
  input logic [INSN_W-1:0] insn,
  input logic              x_ld,
  input logic              y_ld,
  input logic [ADDR_W-1:0] ld_val,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] idx_x,
  input logic [ADDR_W-1:0] idx_y,
  input logic              ext_pending,
  input logic [EXT_W-1:0]  ext_q
);
  localparam int PAGE_W = ADDR_W - EXT_W;
  logic reg_hit, imm_hit;
  assign reg_hit = exec && !pfx && ((insn & INSN_W'('h1FF9)) == INSN_W'('h1EE9));
  assign imm_hit = exec && !pfx && ((insn & INSN_W'('h1FD0)) == INSN_W'('h1E80));

  assert_strobe_src_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(reg_hit || imm_hit));
  assert_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !(reg_hit || imm_hit) |=> !mem_we);
  assert_x_inc_R2: assert property (@(posedge clk) disable iff (rst)
    reg_hit && !insn[1] && !x_ld |=> idx_x == ADDR_W'($past(idx_x) + 1'b1));
  assert_y_inc_R2: assert property (@(posedge clk) disable iff (rst)
    reg_hit && insn[1] && !y_ld |=> idx_y == ADDR_W'($past(idx_y) + 1'b1));
  assert_reg_addr_R5: assert property (@(posedge clk) disable iff (rst)
    reg_hit && !insn[1] |=> mem_addr == $past(idx_x));
  assert_ext_x_R4: assert property (@(posedge clk) disable iff (rst)
    imm_hit && !insn[5] && ext_pending |=> mem_addr == {{PAGE_W{1'b0}}, $past(ext_q)});
  assert_ext_y_R4: assert property (@(posedge clk) disable iff (rst)
    imm_hit && insn[5] && ext_pending |=> mem_addr == {{PAGE_W{1'b1}}, $past(ext_q)});
  assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
    exec && pfx |=> ext_pending && !mem_we);
  assert_pend_clr_R7: assert property (@(posedge clk) disable iff (rst)
    exec && !pfx |=> !ext_pending);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !exec && !x_ld && !y_ld |=> $stable(idx_x) && $stable(idx_y) && $stable(ext_pending) && !mem_we);
  assert_x_load_R10: assert property (@(posedge clk) disable iff (rst)
    x_ld |=> idx_x == $past(ld_val));
endmodule

bind nibble_store_xu nibble_store_xu_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .exec(exec), .pfx(pfx), .insn(insn), .x_ld(x_ld), .y_ld(y_ld),
  .ld_val(ld_val), .mem_we(mem_we), .mem_addr(mem_addr), .idx_x(idx_x), .idx_y(idx_y),
  .ext_pending(ext_pending), .ext_q(ext_q)
);

// File: tb/tb_nibble_store_xu.sv
module tb_nibble_store_xu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec = 1'b0, pfx = 1'b0, x_ld = 1'b0, y_ld = 1'b0;
  logic [12:0] insn = '0;
  logic [7:0]  ext_imm = '0;
  logic [3:0]  reg_a = '0, reg_b = '0;
  logic [15:0] ld_val = '0;
  logic        mem_we, ext_pending;
  logic [15:0] mem_addr, idx_x, idx_y;
  logic [3:0]  mem_wdata;

  int checks = 0, failures = 0;
  logic [15:0] mx = '0, my = '0, e_addr = '0;
  logic [7:0]  mext = '0;
  logic        mpend = 1'b0, e_we = 1'b0;
  logic [3:0]  e_data = '0;

  always #2.5 clk = ~clk;

  nibble_store_xu dut (.*);

  function automatic bit f_reg(logic [12:0] i);
    return (i & 13'h1FF9) == 13'h1EE9;
  endfunction
  function automatic bit f_imm(logic [12:0] i);
    return (i & 13'h1FD0) == 13'h1E80;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit e, bit p, logic [12:0] i, logic [7:0] ei,
                      logic [3:0] a, logic [3:0] b, bit xl, bit yl, logic [15:0] lv);
    bit rg, im, sy;
    exec = e; pfx = p; insn = i; ext_imm = ei; reg_a = a; reg_b = b;
    x_ld = xl; y_ld = yl; ld_val = lv;
    rg = e && !p && f_reg(i);
    im = e && !p && f_imm(i);
    sy = rg ? i[1] : i[5];
    e_we = rg || im;
    if (e_we) begin
      e_addr = (im && mpend) ? (sy ? {8'hFF, mext} : {8'h00, mext}) : (sy ? my : mx);
      e_data = rg ? (i[2] ? b : a) : i[3:0];
    end
    if (e && p) begin mext = ei; mpend = 1'b1; end
    else if (e) mpend = 1'b0;
    if (xl) mx = lv; else if (rg && !i[1]) mx = mx + 16'd1;
    if (yl) my = lv; else if (rg && i[1]) my = my + 16'd1;
    @(posedge clk); #1;
    chk({tag, " we"}, 16'(mem_we), 16'(e_we));
    if (e_we) begin
      chk({tag, " addr"}, mem_addr, e_addr);
      chk({tag, " data"}, 16'(mem_wdata), 16'(e_data));
    end
    chk({tag, " x"}, idx_x, mx);
    chk({tag, " y"}, idx_y, my);
    chk({tag, " pend"}, 16'(ext_pending), 16'(mpend));
  endtask

  task automatic do_reset();
    rst = 1'b1; exec = 1'b0; x_ld = 1'b0; y_ld = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    mx = '0; my = '0; mext = '0; mpend = 1'b0;
    chk("R11 we", 16'(mem_we), 16'd0);
    chk("R11 x", idx_x, 16'd0);
    chk("R11 y", idx_y, 16'd0);
    chk("R11 pend", 16'(ext_pending), 16'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    @(posedge clk); #1;
    do_reset();
    step("R10 load X", 0, 0, 13'h0, 8'h0, 4'h0, 4'h0, 1, 0, 16'hFFFF);
    step("R1 R2 X from A wrap", 1, 0, 13'h1EE9, 8'h0, 4'h5, 4'h9, 0, 0, 16'h0);
    step("R10 load Y", 0, 0, 13'h0, 8'h0, 4'h0, 4'h0, 0, 1, 16'h1234);
    step("R1 R2 Y from B", 1, 0, 13'h1EEF, 8'h0, 4'h3, 4'hA, 0, 0, 16'h0);
    step("R1 X from B", 1, 0, 13'h1EED, 8'h0, 4'h3, 4'hC, 0, 0, 16'h0);
    step("R1 Y from A", 1, 0, 13'h1EEB, 8'h6, 4'hE, 4'h1, 0, 0, 16'h0);
    step("R3 imm X", 1, 0, 13'h1E87, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R3 imm Y", 1, 0, 13'h1EAC, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R6 prefix", 1, 1, 13'h0, 8'h3C, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R6 hold idle", 0, 0, 13'h1EE9, 8'h00, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R4 ext X", 1, 0, 13'h1E85, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R6 prefix", 1, 1, 13'h0, 8'h81, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R4 ext Y", 1, 0, 13'h1EA2, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R6 prefix", 1, 1, 13'h0, 8'h55, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R5 reg ignores ext", 1, 0, 13'h1EEB, 8'h0, 4'h7, 4'h0, 0, 0, 16'h0);
    step("R6 prefix", 1, 1, 13'h0, 8'hAA, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R7 R9 bad opcode clears", 1, 0, 13'h1EE8, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R3 no ext after clear", 1, 0, 13'h1E81, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R9 near miss 1E90", 1, 0, 13'h1E90, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R9 near miss 1EC0", 1, 0, 13'h1EC0, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R9 near miss 1EE1", 1, 0, 13'h1EE1, 8'h0, 4'h2, 4'h2, 0, 0, 16'h0);
    step("R9 no exec", 0, 0, 13'h1EE9, 8'h0, 4'h2, 4'h2, 0, 0, 16'h0);
    step("R8 strobe drops", 0, 0, 13'h0, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    step("R10 load beats inc", 1, 0, 13'h1EE9, 8'h0, 4'hB, 4'h0, 1, 0, 16'h4000);
    step("R8 back to back", 1, 0, 13'h1EEF, 8'h0, 4'h0, 4'hD, 0, 0, 16'h0);
    step("R8 back to back", 1, 0, 13'h1EAF, 8'h0, 4'h0, 4'h0, 0, 0, 16'h0);
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [12:0] op;
      bit p;
      p = ($urandom % 6) == 0;
      case ($urandom % 5)
        0: op = 13'h1EE9 | 13'(($urandom % 4) << 1);
        1: op = 13'h1E80 | 13'($urandom % 16);
        2: op = 13'h1EA0 | 13'($urandom % 16);
        3: op = 13'h1E80 | 13'($urandom % 128);
        default: op = 13'($urandom);
      endcase
      step("RND", ($urandom % 8) != 0, p, op, 8'($urandom), 4'($urandom), 4'($urandom),
           ($urandom % 20) == 0, ($urandom % 20) == 0, 16'($urandom % 4 == 0 ? 16'hFFFE : $urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule